// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block takes the two raw data lines of a low-speed USB port and turns each packet into a byte stream. A free-running clock at eight times the bit rate oversamples both lines after a synchroniser. A phase counter re-centres on every line transition and produces one sample strobe per bit. A small state machine then hunts for the end of the synchronisation pattern, decodes the NRZI stream and removes stuffed bits. It collects bytes least significant bit first, checks the packet identifier and runs a reflected CRC16 over every byte that follows the identifier.

Downstream logic sees each byte after the identifier as a one-cycle valid strobe. The final byte before end of packet also carries a last marker. A one-cycle done pulse carries the packet's status: good, CRC error, stuff error, identifier error or overflow. The four-bit packet identifier is held on its own output. After an aborted packet the receiver stays deaf until the line returns to idle, so the remains of a broken packet cannot be mistaken for a new one.

Top module: `lsusb_rx`

## Requirements
- R1: During and after reset, with the line idle, rx_valid, rx_last, rx_done and all status flags are low.
- R2: Line states are {usb_dp, usb_dm}: J = 01 (idle), K = 10, SE0 = 00. A packet starts only after two consecutive bit samples read K while hunting. A lone K followed by J starts nothing.
- R3: After the start, an unchanged line state between bit samples decodes as 1 and a change decodes as 0. Bits are assembled least significant bit first, and every byte after the identifier appears on rx_data with rx_valid high for one cycle, in arrival order.
- R4: The run of decoded 1s is counted from the first identifier bit. After six 1s inside the bytes that follow the identifier, the next bit must be a transition. That bit is discarded, so a data byte of 0xFF received with stuffing is delivered intact.
- R5: If a bit in a stuffing position shows no transition, the packet ends with rx_done and stuff_err high, pkt_good low, and no byte marked last.
- R6: rx_pid carries bits 3:0 of the identifier byte. pid_err is reported at done when bits 7:4 are not the bitwise inverse of bits 3:0.
- R7: The CRC register starts at 0xFFFF and absorbs each byte after the identifier, LSB first, with reflected polynomial 0xA001. A packet with at least one such byte has crc_err low only if the register ends at 0xB001. A packet with no bytes after the identifier is not CRC checked.
- R8: An SE0 sample ends the packet. The last byte received is delivered with rx_valid and rx_last high in the same cycle as the one-cycle rx_done pulse.
- R9: When more than MAX_BYTES bytes follow the identifier, the packet ends with ovf_err high and pkt_good low. Only the first MAX_BYTES-1 bytes are delivered, none marked last.
- R10: After a stuff or overflow abort, K states on the line are ignored until a J bit sample is seen. No further done pulse comes from the rest of the aborted packet.
- R11: The sample falls half a bit after the last observed transition, so bit periods that alternate between 7 and 9 clocks are received correctly.
- R12: Status flags change only in the rx_done cycle and stay stable otherwise. pkt_good is never high together with any error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, OVS times the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| usb_dp | input | 1 | Raw D+ line |
| usb_dm | input | 1 | Raw D- line |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| rx_last | output | 1 | Marks the final byte of a packet |
| rx_pid | output | 4 | Identifier of the current or latest packet |
| rx_done | output | 1 | One-cycle end-of-packet pulse |
| pkt_good | output | 1 | Packet accepted without error |
| crc_err | output | 1 | CRC16 residual mismatch |
| stuff_err | output | 1 | Stuffing-position bit lacked a transition |
| pid_err | output | 1 | Identifier nibbles not complementary |
| ovf_err | output | 1 | More than MAX_BYTES bytes after identifier |

## Verification
The hardest state to reach from the ports is the lockout after a stuff abort while the line sits at K. Only there can a missing lockout turn the remains of a packet into a false start. The bench disables stuffing in its encoder, sends two 0xFF bytes so that a seventh identical bit hits the stuffing position, and then holds K for several bit times before SE0. It expects exactly one done pulse. Drift tolerance is reached by encoding a whole packet with bit periods alternating between 7 and 9 clocks.

// File: rtl/lsusb_rx_pkg.sv
package lsusb_rx_pkg;
   // {dp, dm}
   typedef enum logic [1:0] {
      LS_SE0 = 2'b00,
      LS_J   = 2'b01,
      LS_K   = 2'b10,
      LS_SE1 = 2'b11
   } line_t;

   typedef enum logic [1:0] {
      ST_HUNT = 2'd0,
      ST_PID  = 2'd1,
      ST_DATA = 2'd2,
      ST_LOCK = 2'd3
   } rx_state_t;

   localparam logic [15:0] CRC_POLY  = 16'hA001;
   localparam logic [15:0] CRC_SEED  = 16'hFFFF;
   localparam logic [15:0] CRC_RESID = 16'hB001;

   function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
         else             r = r >> 1;
      end
      return r;
   endfunction
endpackage

// File: rtl/lsusb_rx_sync.sv
module lsusb_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] raw,
   output logic [1:0] synced
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("lsusb_rx_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         logic [1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= 2'b01;
            else        q <= raw;
         end
         assign synced = q;
      end else begin : g_chain
         logic [STAGES-1:0][1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= {STAGES{2'b01}};
            else        q <= {q[STAGES-2:0], raw};
         end
         assign synced = q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lsusb_rx_dpll.sv
module lsusb_rx_dpll #(
   parameter int OVS = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] line,
   output logic       bit_stb
);
   localparam int CW = $clog2(OVS);
   localparam logic [CW-1:0] SAMPLE_AT = CW'(OVS / 2 - 1);
   localparam logic [CW-1:0] WRAP_AT   = CW'(OVS - 1);

   logic [1:0]    last_line;
   logic [CW-1:0] phase;
   logic          edge_seen;

   assign edge_seen = (line != last_line);
   assign bit_stb   = !edge_seen && (phase == SAMPLE_AT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_line <= 2'b01;
         phase     <= '0;
      end else begin
         last_line <= line;
         if (edge_seen)               phase <= '0;
         else if (phase == WRAP_AT)   phase <= '0;
         else                         phase <= phase + 1'b1;
      end
   end
endmodule

// File: rtl/lsusb_rx_crc.sv
module lsusb_rx_crc
   import lsusb_rx_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        seed,
   input  logic        absorb,
   input  logic [7:0]  din,
   output logic [15:0] crc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc <= CRC_SEED;
      else if (seed)   crc <= CRC_SEED;
      else if (absorb) crc <= crc16_step(crc, din);
   end
endmodule

// File: rtl/lsusb_rx.sv
module lsusb_rx
   import lsusb_rx_pkg::*;
#(
   parameter int OVS         = 8,
   parameter int SYNC_STAGES = 2,
   parameter int MAX_BYTES   = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       usb_dp,
   input  logic       usb_dm,
   output logic [7:0] rx_data,
   output logic       rx_valid,
   output logic       rx_last,
   output logic [3:0] rx_pid,
   output logic       rx_done,
   output logic       pkt_good,
   output logic       crc_err,
   output logic       stuff_err,
   output logic       pid_err,
   output logic       ovf_err
);
   localparam int NBW = $clog2(MAX_BYTES + 1);
   localparam logic [NBW-1:0] NB_LIMIT = NBW'(MAX_BYTES);
   localparam logic [2:0] RUN_LIMIT = 3'd6;

   generate
      if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("lsusb_rx: OVS must be a power of two, at least 4");
      end
      if (MAX_BYTES < 2) begin : g_bad_max
         $error("lsusb_rx: MAX_BYTES must be at least 2");
      end
   endgenerate

   logic [1:0] ln_raw;
   line_t      ln;
   logic       stb;

   lsusb_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw({usb_dp, usb_dm}), .synced(ln_raw)
   );
   assign ln = line_t'(ln_raw);

   lsusb_rx_dpll #(.OVS(OVS)) u_dpll (
      .clk(clk), .rst_n(rst_n), .line(ln_raw), .bit_stb(stb)
   );

   rx_state_t      state;
   line_t          prev_ln;
   logic           prev_k;
   logic [2:0]     run1;
   logic [2:0]     bitn;
   logic [7:0]     shreg;
   logic [7:0]     held;
   logic           held_v;
   logic [NBW-1:0] nbytes;
   logic           pid_bad;
   logic [15:0]    crc_q;

   logic       is_se0, dbit, byte_end, stuff_pos, start_hit, crc_absorb, at_limit;
   logic [7:0] sh_next;
   logic [2:0] run_next;

   always_comb begin
      is_se0     = (ln == LS_SE0);
      dbit       = (ln == prev_ln);
      sh_next    = {dbit, shreg[7:1]};
      byte_end   = (bitn == 3'd7);
      stuff_pos  = (run1 == RUN_LIMIT);
      at_limit   = (nbytes == NB_LIMIT);
      run_next   = dbit ? ((run1 == RUN_LIMIT) ? RUN_LIMIT : run1 + 3'd1) : 3'd0;
      start_hit  = stb && (state == ST_HUNT) && (ln == LS_K) && prev_k;
      crc_absorb = stb && (state == ST_DATA) && !is_se0 && !stuff_pos
                   && byte_end && !at_limit;
   end

   lsusb_rx_crc u_crc (
      .clk(clk), .rst_n(rst_n), .seed(start_hit), .absorb(crc_absorb),
      .din(sh_next), .crc(crc_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_HUNT;
         prev_ln   <= LS_J;
         prev_k    <= 1'b0;
         run1      <= '0;
         bitn      <= '0;
         shreg     <= '0;
         held      <= '0;
         held_v    <= 1'b0;
         nbytes    <= '0;
         pid_bad   <= 1'b0;
         rx_data   <= '0;
         rx_valid  <= 1'b0;
         rx_last   <= 1'b0;
         rx_pid    <= '0;
         rx_done   <= 1'b0;
         pkt_good  <= 1'b0;
         crc_err   <= 1'b0;
         stuff_err <= 1'b0;
         pid_err   <= 1'b0;
         ovf_err   <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         rx_last  <= 1'b0;
         rx_done  <= 1'b0;
         if (stb) begin
            unique case (state)
               ST_LOCK: begin
                  if (ln == LS_J) begin
                     state  <= ST_HUNT;
                     prev_k <= 1'b0;
                  end
               end
               ST_HUNT: begin
                  prev_k <= (ln == LS_K);
                  if (start_hit) begin
                     state   <= ST_PID;
                     prev_ln <= LS_K;
                     run1    <= '0;
                     bitn    <= '0;
                     nbytes  <= '0;
                     held_v  <= 1'b0;
                  end
               end
               ST_PID: begin
                  if (is_se0) begin
                     rx_done   <= 1'b1;
                     pkt_good  <= 1'b0;
                     crc_err   <= 1'b0;
                     stuff_err <= 1'b0;
                     pid_err   <= 1'b1;
                     ovf_err   <= 1'b0;
                     state     <= ST_LOCK;
                  end else begin
                     prev_ln <= ln;
                     shreg   <= sh_next;
                     run1    <= run_next;
                     bitn    <= bitn + 3'd1;
                     if (byte_end) begin
                        pid_bad <= (sh_next[7:4] != ~sh_next[3:0]);
                        rx_pid  <= sh_next[3:0];
                        state   <= ST_DATA;
                     end
                  end
               end
               ST_DATA: begin
                  if (is_se0) begin
                     rx_valid  <= held_v;
                     rx_last   <= held_v;
                     rx_data   <= held;
                     rx_done   <= 1'b1;
                     pid_err   <= pid_bad;
                     crc_err   <= (nbytes != '0) && (crc_q != CRC_RESID);
                     pkt_good  <= !pid_bad && !((nbytes != '0) && (crc_q != CRC_RESID));
                     stuff_err <= 1'b0;
                     ovf_err   <= 1'b0;
                     state     <= ST_LOCK;
                  end else begin
                     prev_ln <= ln;
                     if (stuff_pos) begin
                        if (dbit) begin
                           rx_done   <= 1'b1;
                           pkt_good  <= 1'b0;
                           crc_err   <= 1'b0;
                           stuff_err <= 1'b1;
                           pid_err   <= pid_bad;
                           ovf_err   <= 1'b0;
                           state     <= ST_LOCK;
                        end else begin
                           run1 <= '0;
                        end
                     end else begin
                        shreg <= sh_next;
                        run1  <= run_next;
                        bitn  <= bitn + 3'd1;
                        if (byte_end) begin
                           if (at_limit) begin
                              rx_done   <= 1'b1;
                              pkt_good  <= 1'b0;
                              crc_err   <= 1'b0;
                              stuff_err <= 1'b0;
                              pid_err   <= pid_bad;
                              ovf_err   <= 1'b1;
                              state     <= ST_LOCK;
                           end else begin
                              nbytes <= nbytes + 1'b1;
                              held   <= sh_next;
                              held_v <= 1'b1;
                              if (held_v) begin
                                 rx_valid <= 1'b1;
                                 rx_data  <= held;
                              end
                           end
                        end
                     end
                  end
               end
               default: state <= ST_LOCK;
            endcase
         end
      end
   end
endmodule

// File: rtl/lsusb_rx_chk.sv
module lsusb_rx_chk #(
   parameter int MAX_BYTES = 10
) (
   input logic clk,
   input logic rst_n,
   input logic rx_valid,
   input logic rx_last,
   input logic rx_done,
   input logic pkt_good,
   input logic crc_err,
   input logic stuff_err,
   input logic pid_err,
   input logic ovf_err
);
   localparam int VW = $clog2(MAX_BYTES + 2);
   logic [VW-1:0] vcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        vcnt <= '0;
      else if (rx_done)  vcnt <= '0;
      else if (rx_valid) vcnt <= vcnt + 1'b1;
   end

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done |=> !rx_done);

   // R12
   good_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && pkt_good) |-> !(crc_err || stuff_err || pid_err || ovf_err));

   // R12
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_done |-> $stable({pkt_good, crc_err, stuff_err, pid_err, ovf_err}));

   // R8
   last_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_last) |-> rx_done);

   // R5
   abort_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && (stuff_err || ovf_err)) |-> !rx_last);

   // R9
   byte_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (vcnt < VW'(MAX_BYTES)));
endmodule

bind lsusb_rx lsusb_rx_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_last(rx_last),
   .rx_done(rx_done), .pkt_good(pkt_good), .crc_err(crc_err),
   .stuff_err(stuff_err), .pid_err(pid_err), .ovf_err(ovf_err)
);

// File: tb/lsusb_rx_bench.sv
module lsusb_rx_bench;
   localparam int MAXB = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic usb_dp = 1'b0;
   logic usb_dm = 1'b1;
   logic [7:0] rx_data;
   logic rx_valid, rx_last, rx_done, pkt_good, crc_err, stuff_err, pid_err, ovf_err;
   logic [3:0] rx_pid;

   always #2.5 clk = ~clk;

   lsusb_rx #(.OVS(8), .SYNC_STAGES(2), .MAX_BYTES(MAXB)) u_lsusb_rx (
      .clk(clk), .rst_n(rst_n), .usb_dp(usb_dp), .usb_dm(usb_dm),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last),
      .rx_pid(rx_pid), .rx_done(rx_done), .pkt_good(pkt_good),
      .crc_err(crc_err), .stuff_err(stuff_err), .pid_err(pid_err),
      .ovf_err(ovf_err)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // monitor
   logic [7:0] mon_b [0:63];
   int  mon_n = 0;
   int  mon_last_n = 0;
   int  done_n = 0;
   logic [4:0] mon_flags = '0; // good, crc, stuff, pid, ovf

   always @(negedge clk) begin
      if (rx_valid) begin
         if (mon_n < 64) mon_b[mon_n] = rx_data;
         mon_n = mon_n + 1;
         if (rx_last) mon_last_n = mon_last_n + 1;
      end
      if (rx_done) begin
         done_n = done_n + 1;
         mon_flags = {pkt_good, crc_err, stuff_err, pid_err, ovf_err};
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // encoder
   logic [7:0] pk [0:31];
   int  pk_n = 0;
   logic [1:0] cur_ln = 2'b01;
   int  run1 = 0;
   int  bit_idx = 0;
   bit  jitter = 0;

   task automatic put_ln(input logic [1:0] l);
      int w;
      w = jitter ? ((bit_idx % 2) ? 9 : 7) : 8;
      bit_idx++;
      {usb_dp, usb_dm} = l;
      repeat (w) @(negedge clk);
   endtask

   task automatic put_bit(input bit b);
      if (!b) cur_ln = (cur_ln == 2'b01) ? 2'b10 : 2'b01;
      put_ln(cur_ln);
   endtask

   task automatic send_byte(input logic [7:0] v, input bit stuff_en);
      for (int i = 0; i < 8; i++) begin
         put_bit(v[i]);
         if (v[i]) run1++; else run1 = 0;
         if (run1 == 6 && stuff_en) begin
            put_bit(1'b0);
            run1 = 0;
         end
      end
   endtask

   function automatic logic [15:0] crc_of(input int from, input int upto);
      logic [15:0] c;
      c = 16'hFFFF;
      for (int k = from; k < upto; k++)
         for (int i = 0; i < 8; i++)
            c = (c[0] ^ pk[k][i]) ? ((c >> 1) ^ 16'hA001) : (c >> 1);
      return c;
   endfunction

   task automatic add_crc();
      logic [15:0] c;
      c = ~crc_of(1, pk_n);
      pk[pk_n] = c[7:0];
      pk[pk_n+1] = c[15:8];
      pk_n += 2;
   endtask

   task automatic send_pkt(input bit stuff_en, input bit tail_k);
      mon_n = 0;
      mon_last_n = 0;
      cur_ln = 2'b01;
      put_ln(2'b01);
      put_ln(2'b01);
      send_byte(8'h80, 1'b0);
      run1 = 0;
      for (int k = 0; k < pk_n; k++) send_byte(pk[k], stuff_en);
      if (tail_k) begin
         cur_ln = 2'b10;
         for (int i = 0; i < 5; i++) put_ln(2'b10);
      end
      put_ln(2'b00);
      put_ln(2'b00);
      for (int i = 0; i < 4; i++) put_ln(2'b01);
      jitter = 0;
   endtask

   task automatic check_bytes(input string req);
      for (int k = 1; k < pk_n; k++)
         chk(k - 1 < 64 && mon_b[k-1] == pk[k], req, int'(mon_b[k-1]), int'(pk[k]));
   endtask

   task automatic t_reset();
      chk(done_n == 0 && rx_valid == 0 && rx_last == 0, "R1 no strobes", done_n, 0);
      chk({pkt_good, crc_err, stuff_err, pid_err, ovf_err} == 5'b0, "R1 flags",
          int'({pkt_good, crc_err, stuff_err, pid_err, ovf_err}), 0);
   endtask

   task automatic t_false_sync();
      int d0;
      d0 = done_n;
      cur_ln = 2'b01;
      put_ln(2'b10); put_ln(2'b01); put_ln(2'b10); put_ln(2'b01);
      put_ln(2'b00); put_ln(2'b00);
      for (int i = 0; i < 4; i++) put_ln(2'b01);
      chk(done_n == d0, "R2 lone K starts nothing", done_n - d0, 0);
   endtask

   task automatic t_data_pkt();
      int d0;
      d0 = done_n;
      pk[0] = 8'hC3; pk[1] = 8'h12; pk[2] = 8'hA5; pk[3] = 8'h3C; pk_n = 4;
      add_crc();
      send_pkt(1'b1, 1'b0);
      chk(done_n == d0 + 1, "R8 one done", done_n - d0, 1);
      chk(mon_flags == 5'b10000, "R7 good crc", int'(mon_flags), 16);
      chk(mon_n == pk_n - 1, "R3 byte count", mon_n, pk_n - 1);
      check_bytes("R3 byte value");
      chk(mon_last_n == 1, "R8 last marker", mon_last_n, 1);
      chk(rx_pid == 4'h3, "R6 pid value", int'(rx_pid), 3);
   endtask

   task automatic t_stuffed();
      pk[0] = 8'h4B; pk[1] = 8'hFF; pk[2] = 8'hFF; pk[3] = 8'h7E; pk_n = 4;
      add_crc();
      send_pkt(1'b1, 1'b0);
      chk(mon_flags == 5'b10000, "R4 good after unstuff", int'(mon_flags), 16);
      chk(mon_n == pk_n - 1, "R4 byte count", mon_n, pk_n - 1);
      check_bytes("R4 unstuffed byte");
   endtask

   task automatic t_handshake();
      pk[0] = 8'hD2; pk_n = 1;
      send_pkt(1'b1, 1'b0);
      chk(mon_flags == 5'b10000, "R7 no crc on empty", int'(mon_flags), 16);
      chk(mon_n == 0, "R8 no bytes", mon_n, 0);
      chk(rx_pid == 4'h2, "R6 handshake pid", int'(rx_pid), 2);
   endtask

   task automatic t_pid_err();
      pk[0] = 8'hC4; pk[1] = 8'h55; pk_n = 2;
      add_crc();
      send_pkt(1'b1, 1'b0);
      chk(mon_flags == 5'b00010, "R6 pid error", int'(mon_flags), 2);
   endtask

   task automatic t_crc_err();
      pk[0] = 8'hC3; pk[1] = 8'h01; pk[2] = 8'h02; pk_n = 3;
      add_crc();
      pk[2] = 8'h03;
      send_pkt(1'b1, 1'b0);
      chk(mon_flags == 5'b01000, "R7 crc error", int'(mon_flags), 8);
      chk(mon_last_n == 1, "R8 last on crc error", mon_last_n, 1);
   endtask

   task automatic t_stuff_err();
      int d0;
      d0 = done_n;
      pk[0] = 8'hC3; pk[1] = 8'hFF; pk[2] = 8'hFF; pk_n = 3;
      send_pkt(1'b0, 1'b1);
      chk(mon_flags == 5'b00100, "R5 stuff error", int'(mon_flags), 4);
      chk(mon_last_n == 0, "R5 no last", mon_last_n, 0);
      chk(done_n == d0 + 1, "R10 lockout single done", done_n - d0, 1);
   endtask

   task automatic t_overflow();
      pk[0] = 8'hC3;
      for (int k = 1; k <= MAXB - 1; k++) pk[k] = 8'(k * 17);
      pk_n = MAXB;
      add_crc();
      send_pkt(1'b1, 1'b0);
      chk(mon_flags == 5'b00001, "R9 overflow", int'(mon_flags), 1);
      chk(mon_n == MAXB - 1, "R9 delivered bytes", mon_n, MAXB - 1);
      chk(mon_last_n == 0, "R9 no last", mon_last_n, 0);
   endtask

   task automatic t_at_limit();
      pk[0] = 8'hC3;
      for (int k = 1; k <= MAXB - 2; k++) pk[k] = 8'(k * 29 + 3);
      pk_n = MAXB - 1;
      add_crc();
      send_pkt(1'b1, 1'b0);
      chk(mon_flags == 5'b10000, "R9 exactly full good", int'(mon_flags), 16);
      chk(mon_n == MAXB, "R9 full byte count", mon_n, MAXB);
   endtask

   task automatic t_jitter();
      pk[0] = 8'h4B; pk[1] = 8'h00; pk[2] = 8'hF0; pk[3] = 8'hFF; pk_n = 4;
      add_crc();
      jitter = 1;
      bit_idx = 0;
      send_pkt(1'b1, 1'b0);
      chk(mon_flags == 5'b10000, "R11 drift tolerance", int'(mon_flags), 16);
      check_bytes("R11 byte value");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (40) @(negedge clk);
      t_reset();
      t_false_sync();
      t_data_pkt();
      t_stuffed();
      t_handshake();
      t_pid_err();
      t_crc_err();
      t_stuff_err();
      t_overflow();
      t_at_limit();
      t_jitter();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule